// File: doc/BRIEF.md
# Gold-Code Random Demodulator Datapath

This block is the digital core of a compressive-sensing random demodulator. Each accepted input sample is one chip: a signed sample is multiplied by a ±1 pseudo-random chip and the product is added into an integrator. After five accepted chips the integrator is dumped and cleared. The dump is quantised to a 10-bit offset-binary code with saturation. The chip stream is a Gold code of period 127. It is formed from two 7-stage maximal-length shift registers.

Each dump also carries a 7-bit chip-phase tag. The tag is the position, in the 127-chip sequence, of the first chip of that window. Software uses it to line up the rows of the measurement matrix with the samples. Five does not divide 127, so consecutive tags drift through every phase.

Both edges of the block use valid/ready handshakes. An output sample stays valid until `out_ready` accepts it. While a sample is pending and `out_ready` is low, `in_ready` drops. No chip is consumed in that state, so no dump can be lost. When `in_valid` is low the sequence, the phase counter and the integrator all hold.

Top module: `rd_chip_datapath`

## Requirements
- R1: On synchronous reset, `out_valid` is 0 and `in_ready` is 1. Shift register A loads 7'h01 and shift register B loads 7'h7F. The chip-phase counter loads 0 and the integrator loads 0.
- R2: Each shift register shifts one stage toward bit 0 (its output) per accepted chip and feeds its taps back into bit 6. For A the feedback is s0^s3. For B the feedback is s0^s1^s2^s3. A register never holds all zeros.
- R3: The chip is A.s0 ^ B.s0, and the chip sequence repeats with period 127.
- R4: Chip 0 multiplies the sample by +1 and chip 1 multiplies it by −1.
- R5: Every fifth accepted chip ends a window. That chip's product is included in the dumped sum, and the integrator restarts from zero.
- R6: The code is floor(sum/8)+512, clamped to the range 0..1023.
- R7: `out_tag` is the phase (0..126, wrapping after 126) of the first chip in the window.
- R8: When `in_valid` is low, nothing advances: the sequence, the phase counter and the integrator all hold.
- R9: `in_ready` equals !out_valid || out_ready. While `out_valid` is high and `out_ready` is low, `out_code` and `out_tag` stay stable.
- R10: If `out_ready` stays high, `out_valid` is high for exactly one cycle per dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can accept a chip |
| in_data | input | 12 | Signed input sample |
| out_valid | output | 1 | Dumped code is valid |
| out_ready | input | 1 | Consumer accepts the code |
| out_code | output | 10 | Offset-binary sample code |
| out_tag | output | 7 | Phase of first chip of window |

## Verification
The assertions assume that `in_valid` and `out_ready` are known (never X) on every clock edge after reset. They also assume that the consumer may hold `out_ready` low for as long as it likes. The bench drives both signals from $urandom at the falling edge, so they are always defined at the sampling edge. Its directed phases include long back-pressure and idle stretches, plus full-scale runs of +2047 and −2048 that drive the code into both saturation limits.

// File: rtl/rd_pkg.sv
package rd_pkg;
  localparam int LFSR_N = 7;
  localparam logic [LFSR_N-1:0] SEED_A = 7'h01;
  localparam logic [LFSR_N-1:0] SEED_B = 7'h7F;
  // feedback masks: bit i set means stage i joins the XOR into the top stage
  localparam logic [LFSR_N-1:0] MASK_A = 7'b0001001;
  localparam logic [LFSR_N-1:0] MASK_B = 7'b0001111;
endpackage

// File: rtl/rd_lfsr.sv
module rd_lfsr #(
  parameter int N = 7,
  parameter logic [N-1:0] SEED = '1,
  parameter logic [N-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic         out_bit,
  output logic [N-1:0] state
);
  logic fb;
  assign fb      = ^(state & MASK);
  assign out_bit = state[0];

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (step) state <= {fb, state[N-1:1]};
  end

  a_r2_never_zero: assert property (@(posedge clk) disable iff (rst)
    state != '0);
  a_r8_hold_lfsr: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state));
endmodule

// File: rtl/rd_gold.sv
module rd_gold
  import rd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic chip
);
  logic bit_a, bit_b;
  logic [LFSR_N-1:0] st_a, st_b;

  rd_lfsr #(.N(LFSR_N), .SEED(SEED_A), .MASK(MASK_A)) u_a (
    .clk(clk), .rst(rst), .step(step), .out_bit(bit_a), .state(st_a));
  rd_lfsr #(.N(LFSR_N), .SEED(SEED_B), .MASK(MASK_B)) u_b (
    .clk(clk), .rst(rst), .step(step), .out_bit(bit_b), .state(st_b));

  assign chip = bit_a ^ bit_b;
endmodule

// File: rtl/rd_integrator.sv
module rd_integrator #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 10,
  parameter int DECIM = 5,
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             chip,
  input  logic [IN_W-1:0]  sample,
  input  logic [TAG_W-1:0] phase,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_code,
  output logic [TAG_W-1:0] out_tag
);
  localparam int ACC_W = IN_W + 1 + $clog2(DECIM);
  localparam int SHIFT = IN_W + 1 - OUT_W;
  localparam int PW    = $clog2(DECIM);
  localparam logic signed [ACC_W-1:0] MID_S = ACC_W'(1 << (OUT_W - 1));
  localparam logic signed [ACC_W-1:0] MAX_S = ACC_W'((1 << OUT_W) - 1);

  logic signed [ACC_W-1:0] acc, prod_x, sum_full, scaled, biased;
  logic signed [IN_W:0]    s_ext;
  logic [PW-1:0]           pos;
  logic [TAG_W-1:0]        win_tag;
  logic [OUT_W-1:0]        code_q;
  logic                    last;

  assign s_ext    = $signed({sample[IN_W-1], sample});
  assign prod_x   = chip ? ACC_W'(-s_ext) : ACC_W'(s_ext);
  assign sum_full = acc + prod_x;
  assign scaled   = sum_full >>> SHIFT;
  assign biased   = scaled + MID_S;
  assign last     = (pos == PW'(DECIM - 1));

  always_comb begin
    if (biased < 0)          code_q = '0;
    else if (biased > MAX_S) code_q = '1;
    else                     code_q = biased[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      pos       <= '0;
      win_tag   <= '0;
      out_valid <= 1'b0;
      out_code  <= '0;
      out_tag   <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fire) begin
        if (pos == '0) win_tag <= phase;
        if (last) begin
          acc       <= '0;
          pos       <= '0;
          out_valid <= 1'b1;
          out_code  <= code_q;
          out_tag   <= win_tag;
        end else begin
          acc <= sum_full;
          pos <= pos + 1'b1;
        end
      end
    end
  end

  a_r5_pos_range: assert property (@(posedge clk) disable iff (rst)
    pos <= PW'(DECIM - 1));
  a_r5_clear_after_dump: assert property (@(posedge clk) disable iff (rst)
    fire && last |=> acc == '0 && out_valid);
  a_r8_hold_acc: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(acc) && $stable(pos));
  a_r9_hold_output: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_tag));
endmodule

// File: rtl/rd_chip_datapath.sv
module rd_chip_datapath #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 10,
  parameter int DECIM = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_code,
  output logic [6:0]       out_tag
);
  localparam int PERIOD = (1 << rd_pkg::LFSR_N) - 1;
  localparam int TAG_W  = 7;

  logic             fire, chip;
  logic [TAG_W-1:0] phase;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (fire) phase <= (phase == TAG_W'(PERIOD - 1)) ? '0 : phase + 1'b1;
  end

  rd_gold u_gold (.clk(clk), .rst(rst), .step(fire), .chip(chip));

  rd_integrator #(.IN_W(IN_W), .OUT_W(OUT_W), .DECIM(DECIM), .TAG_W(TAG_W)) u_int (
    .clk(clk), .rst(rst), .fire(fire), .chip(chip), .sample(in_data),
    .phase(phase), .out_ready(out_ready), .out_valid(out_valid),
    .out_code(out_code), .out_tag(out_tag));

  a_r7_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase < TAG_W'(PERIOD));
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(phase));
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid || $past(fire));
endmodule

// File: tb/tb_rd_chip_datapath.sv
module tb_rd_chip_datapath;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1, in_valid = 0, out_ready = 1;
  logic [11:0] in_data = '0;
  logic in_ready, out_valid;
  logic [9:0] out_code;
  logic [6:0] out_tag;

  int n_chk = 0, n_err = 0, seed_dummy;
  bit done = 0;

  logic [6:0] ma, mb;
  int m_idx, m_pos, m_sum, m_tag_w, m_code, m_tag, m_valid_pulses, prev_v;
  bit m_valid;

  always #(CLK_P/2) clk = ~clk;

  rd_chip_datapath dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_tag(out_tag));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int quant(int s);
    int q;
    q = (s >= 0) ? s / 8 : -((-s + 7) / 8);
    q = q + 512;
    if (q < 0) q = 0;
    if (q > 1023) q = 1023;
    return q;
  endfunction

  function automatic logic [6:0] step_a(logic [6:0] s);
    return {s[0] ^ s[3], s[6:1]};
  endfunction
  function automatic logic [6:0] step_b(logic [6:0] s);
    return {s[0] ^ s[1] ^ s[2] ^ s[3], s[6:1]};
  endfunction

  task automatic model_reset();
    ma = 7'h01; mb = 7'h7F; m_idx = 0; m_pos = 0; m_sum = 0;
    m_tag_w = 0; m_valid = 0; m_code = 0; m_tag = 0;
  endtask

  // one cycle: check outputs at negedge, apply inputs, advance model at posedge
  task automatic cycle(bit v, bit rdy, logic [11:0] d);
    bit fire, c;
    int p;
    @(negedge clk);
    chk("R1 R9 out_valid", out_valid, m_valid);
    if (m_valid) begin
      chk("R3 R4 R5 R6 out_code", out_code, m_code);
      chk("R7 out_tag", out_tag, m_tag);
    end
    in_valid = v; out_ready = rdy; in_data = d;
    #1;
    chk("R9 in_ready", in_ready, (!m_valid || rdy));
    fire = v && (!m_valid || rdy);
    @(posedge clk);
    if (m_valid && rdy) m_valid = 0;
    if (fire) begin
      c = ma[0] ^ mb[0];
      p = c ? -$signed(d) : $signed(d);
      if (m_pos == 0) m_tag_w = m_idx;
      if (m_pos == 4) begin
        m_code = quant(m_sum + p); m_tag = m_tag_w; m_valid = 1;
        m_sum = 0; m_pos = 0;
      end else begin
        m_sum += p; m_pos++;
      end
      m_idx = (m_idx == 126) ? 0 : m_idx + 1;
      ma = step_a(ma); mb = step_b(mb);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [6:0] ta, tb;
    int first_ret;
    seed_dummy = $urandom(32'h5EED1234);
    model_reset();
    // R3: reference sequence period from the stated polynomials and seeds
    ta = 7'h01; tb = 7'h7F; first_ret = 0;
    for (int k = 1; k <= 127; k++) begin
      ta = step_a(ta); tb = step_b(tb);
      if (ta == 7'h01 && tb == 7'h7F && first_ret == 0) first_ret = k;
    end
    chk("R3 period", first_ret, 127);

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset in_ready", in_ready, 1);

    // random, consumer always ready: one-cycle pulses (R10)
    prev_v = 0;
    for (int i = 0; i < 600; i++) begin
      cycle(($urandom % 4) != 0, 1'b1, 12'($urandom));
      if (prev_v == 1) chk("R10 single cycle pulse", int'(m_valid), 0);
      prev_v = m_valid;
    end
    // saturation high and low (R6)
    for (int i = 0; i < 300; i++) cycle(1'b1, 1'b1, 12'h7FF);
    for (int i = 0; i < 300; i++) cycle(1'b1, 1'b1, 12'h800);
    // idle: nothing advances (R8)
    for (int i = 0; i < 40; i++) begin
      cycle(1'b0, 1'b1, 12'($urandom));
      chk("R8 idle no dump", out_valid, 0);
    end
    // back-pressure (R9)
    for (int i = 0; i < 2000; i++)
      cycle(($urandom % 8) != 0, ($urandom % 3) == 0, 12'($urandom));
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b0, 12'($urandom));
    for (int i = 0; i < 3000; i++)
      cycle(($urandom % 2) == 0, ($urandom % 4) != 0, 12'($urandom));
    // small values near mid-code
    for (int i = 0; i < 500; i++)
      cycle(1'b1, 1'b1, 12'($signed(($urandom % 64)) - 32));
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule